// File: doc/BRIEF.md
# Three-Phase Sine-Triangle PWM Modulator

This block generates the gate commands for a three-leg voltage-source inverter by naturally comparing three sine references against one shared triangular carrier. The references are spaced a third of a turn apart. Their amplitude is set by a modulation depth word, their frequency by a phase increment added to an accumulator on every clock, and the carrier period by a count limit. Each leg has an upper-switch command that is high while its reference lies above the carrier. The lower-switch command is the complement of the upper one. Dead time is added downstream of this block.

An optional third-harmonic term of one sixth of the fundamental amplitude can be added to every reference. This flattens the reference peaks, so the depth can rise about 15.5 % above unity before any pulse is dropped. Beyond that point a reference saturates at the carrier bounds, and its leg stays on one rail for the whole carrier period. A direction input exchanges the second and third references, which reverses the phase sequence. The references are sampled at every carrier peak and valley, so an edge can move only at a sampling instant.

The carrier is an up/down counter run by a three-state machine. `CR_START` is the reset state. It always moves to `CR_FALL` on the next clock (transition *arm*). In `CR_FALL` the count steps down. At zero the machine raises the valley strobe, loads the period and moves to `CR_RISE` with count 1 (transition *valley turn*). In `CR_RISE` the count steps up. At the loaded period the machine raises the peak strobe and moves back to `CR_FALL` with count period−1 (transition *peak turn*).

Top module: `spwm3_mod`

## Requirements
- R1: The carrier counts 0,1,…,P,P−1,…,1,0 and repeats, so successive valleys are 2·P clocks apart. P is `carrier_period` captured at each valley, and a value below 2 is taken as 2. After a valley the count is 1.
- R2: `peak_stb` is high for exactly one clock while the rising count equals P. `valley_stb` is high for one clock while the falling count equals 0. The two strobes are never high together.
- R3: The phase accumulator θ (16 bits, 0 after reset) adds `phase_inc` modulo 2^16 on every clock after reset.
- R4: The sine sample for an 8-bit index i is round(2047·sin(2π(i+0.5)/256)), with halves rounded away from zero.
- R5: The leg phases are θ, θ−21845 and θ+21845, all modulo 2^16. Each leg's index is bits 15:8 of its phase.
- R6: The reference is R = m·(6·s(i) + e·s((3i+1) mod 256)). Here m is `mod_depth` read as unsigned with 8 fractional bits, and e is `inj_en`. With K = 6·2047·256 and level L = R+K, the upper command of a leg is high when L·P > 2K·c, where c is the carrier count.
- R7: R for all legs is computed from θ, `mod_depth`, `inj_en` and `seq_rev` on the clock where a strobe is high, and is held until the next strobe. Input changes between strobes do not change the outputs.
- R8: R is clamped to [−K, K]. A leg whose L equals 2K keeps its upper command high for every count, including the peak. A leg whose L equals 0 keeps it low.
- R9: With `seq_rev` = 1, the second leg uses θ+21845 and the third leg uses θ−21845.
- R10: `pwm_lo` is the bitwise complement of `pwm_hi` on every cycle.
- R11: During reset, and until the first valley, every held level is K and the carrier sits at 0. This gives `pwm_hi` = 3'b111, `pwm_lo` = 3'b000 and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_depth | input | 10 | Modulation depth, unsigned, 8 fractional bits |
| phase_inc | input | 16 | Output-frequency phase step per clock |
| carrier_period | input | 12 | Carrier half-period in clocks, minimum 2 |
| inj_en | input | 1 | Adds the one-sixth third-harmonic term |
| seq_rev | input | 1 | Exchanges the second and third leg references |
| pwm_hi | output | 3 | Upper-switch commands, bit 0 is the first leg |
| pwm_lo | output | 3 | Lower-switch commands |
| peak_stb | output | 1 | One-clock carrier peak strobe |
| valley_stb | output | 1 | One-clock carrier valley strobe |

## Verification
The strobes follow the carrier state with no delay. A new reference therefore shows at `pwm_hi` on the first clock after the edge that ends a strobe cycle. A new period takes effect only from the next valley, so it appears a full carrier cycle or more after the write. The bench holds a behavioural model that advances on each rising edge from the same inputs, and it compares every output at the following falling edge. Because of this, a change to depth, injection, direction or period is only expected to show at the strobe-delayed cycle the requirements name. Carrier spacing is measured separately by counting clocks between valleys.

// File: rtl/spwm3_pkg.sv
package spwm3_pkg;

    typedef enum logic [1:0] {
        CR_START = 2'd0,
        CR_FALL  = 2'd1,
        CR_RISE  = 2'd2
    } car_st_e;

endpackage

// File: rtl/spwm3_carrier.sv
module spwm3_carrier
    import spwm3_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_in,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per,
    output logic             peak,
    output logic             valley
);

    localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);

    car_st_e          st, st_nx;
    logic [CNT_W-1:0] cnt_nx, per_nx, per_eff;

    always_comb begin
        per_eff = (period_in < MIN_PER) ? MIN_PER : period_in;
    end

    // next-state and next-count
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        per_nx = per;
        unique case (st)
            CR_START: st_nx = CR_FALL;
            CR_FALL: begin
                if (cnt == '0) begin
                    per_nx = per_eff;
                    cnt_nx = CNT_W'(1);
                    st_nx  = CR_RISE;
                end else begin
                    cnt_nx = cnt - CNT_W'(1);
                end
            end
            CR_RISE: begin
                if (cnt == per) begin
                    cnt_nx = per - CNT_W'(1);
                    st_nx  = CR_FALL;
                end else begin
                    cnt_nx = cnt + CNT_W'(1);
                end
            end
            default: st_nx = CR_START;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= CR_START;
            cnt <= '0;
            per <= MIN_PER;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            per <= per_nx;
        end
    end

    // outputs
    always_comb begin
        peak   = (st == CR_RISE) && (cnt == per);
        valley = (st == CR_FALL) && (cnt == '0);
    end

endmodule

// File: rtl/spwm3_sine_lut.sv
module spwm3_sine_lut #(
    parameter int IDX_W = 8,
    parameter int AMP_W = 12
) (
    input  logic [IDX_W-1:0]        idx,
    output logic signed [AMP_W-1:0] val
);

    localparam int  Q_W = IDX_W - 2;
    localparam int  QN  = 2 ** Q_W;
    localparam real AMP = real'(2 ** (AMP_W - 1) - 1);
    localparam real HPI = 1.5707963267948966;

    logic [AMP_W-2:0] qtab [QN];

    // first quadrant, sampled at half-step offsets so the quadrants mirror exactly
    for (genvar k = 0; k < QN; k++) begin : g_tab
        localparam real ANG = HPI * (real'(k) + 0.5) / real'(QN);
        assign qtab[k] = (AMP_W-1)'($rtoi(AMP * $sin(ANG) + 0.5));
    end

    logic [1:0]       quad;
    logic [Q_W-1:0]   k_in, addr;
    logic [AMP_W-2:0] mag;

    always_comb begin
        quad = idx[IDX_W-1 -: 2];
        k_in = idx[Q_W-1:0];
        addr = quad[0] ? ~k_in : k_in;
        mag  = qtab[addr];
        val  = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

endmodule

// File: rtl/spwm3_ref.sv
module spwm3_ref #(
    parameter int     IDX_W  = 8,
    parameter int     AMP_W  = 12,
    parameter int     M_W    = 10,
    parameter longint HALF   = 3144192,
    parameter int     LV_W   = 23
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [M_W-1:0]   m,
    input  logic             inj,
    output logic [LV_W-1:0]  lvl
);

    localparam int V_W = AMP_W + 4;
    localparam int R_W = V_W + M_W + 1;
    localparam logic signed [R_W-1:0] KS = R_W'(HALF);

    logic [IDX_W-1:0]        idx3;
    logic signed [AMP_W-1:0] s1, s3;
    logic signed [V_W-1:0]   s1x, s3x, v;
    logic signed [R_W-1:0]   vx, mx, r;

    // sin(3x) at the half-step grid: index 3i+1
    assign idx3 = idx + {idx[IDX_W-2:0], 1'b0} + IDX_W'(1);

    spwm3_sine_lut #(.IDX_W(IDX_W), .AMP_W(AMP_W)) u_fund (.idx(idx),  .val(s1));
    spwm3_sine_lut #(.IDX_W(IDX_W), .AMP_W(AMP_W)) u_thrd (.idx(idx3), .val(s3));

    always_comb begin
        s1x = $signed({{(V_W-AMP_W){s1[AMP_W-1]}}, s1});
        s3x = $signed({{(V_W-AMP_W){s3[AMP_W-1]}}, s3});
        v   = (s1x <<< 2) + (s1x <<< 1) + (inj ? s3x : '0);
        vx  = $signed({{(R_W-V_W){v[V_W-1]}}, v});
        mx  = $signed({{(R_W-M_W){1'b0}}, m});
        r   = vx * mx;
        if (r >= KS) begin
            lvl = LV_W'(2 * HALF);
        end else if (r <= -KS) begin
            lvl = '0;
        end else begin
            lvl = LV_W'(r + KS);
        end
    end

endmodule

// File: rtl/spwm3_mod.sv
module spwm3_mod #(
    parameter int PH_W   = 16,
    parameter int IDX_W  = 8,
    parameter int AMP_W  = 12,
    parameter int M_W    = 10,
    parameter int M_FRAC = 8,
    parameter int CNT_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [M_W-1:0]   mod_depth,
    input  logic [PH_W-1:0]  phase_inc,
    input  logic [CNT_W-1:0] carrier_period,
    input  logic             inj_en,
    input  logic             seq_rev,
    output logic [2:0]       pwm_hi,
    output logic [2:0]       pwm_lo,
    output logic             peak_stb,
    output logic             valley_stb
);

    localparam longint HALF = 6 * longint'(2 ** (AMP_W - 1) - 1) * longint'(2 ** M_FRAC);
    localparam longint FULL = 2 * HALF;
    localparam int     LV_W = $clog2(FULL + 1);
    localparam int     P_W  = LV_W + CNT_W;
    localparam logic [PH_W-1:0] OFS = PH_W'(((longint'(1) << PH_W) + 1) / 3);

    logic [CNT_W-1:0]           car_cnt, car_per;
    logic [PH_W-1:0]            theta_q;
    logic [2:0][PH_W-1:0]       ph;
    logic [2:0][LV_W-1:0]       lvl_nx, lvl_q;
    logic [P_W-1:0]             car_scaled;
    logic                       sample;

    spwm3_carrier #(.CNT_W(CNT_W)) u_car (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_in(carrier_period),
        .cnt      (car_cnt),
        .per      (car_per),
        .peak     (peak_stb),
        .valley   (valley_stb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) theta_q <= '0;
        else        theta_q <= theta_q + phase_inc;
    end

    always_comb begin
        ph[0] = theta_q;
        ph[1] = seq_rev ? theta_q + OFS : theta_q - OFS;
        ph[2] = seq_rev ? theta_q - OFS : theta_q + OFS;
    end

    assign sample     = peak_stb | valley_stb;
    assign car_scaled = P_W'(FULL) * P_W'(car_cnt);

    for (genvar p = 0; p < 3; p++) begin : g_leg
        spwm3_ref #(
            .IDX_W(IDX_W), .AMP_W(AMP_W), .M_W(M_W), .HALF(HALF), .LV_W(LV_W)
        ) u_ref (
            .idx(ph[p][PH_W-1 -: IDX_W]),
            .m  (mod_depth),
            .inj(inj_en),
            .lvl(lvl_nx[p])
        );
        assign pwm_hi[p] = (lvl_q[p] == LV_W'(FULL)) ||
                           ((P_W'(lvl_q[p]) * P_W'(car_per)) > car_scaled);
    end

    // regular sampling at every peak and valley
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < 3; p++) lvl_q[p] <= LV_W'(HALF);
        end else if (sample) begin
            for (int p = 0; p < 3; p++) lvl_q[p] <= lvl_nx[p];
        end
    end

    assign pwm_lo = ~pwm_hi;

endmodule

// File: rtl/spwm3_check.sv
module spwm3_check #(
    parameter int CNT_W = 12,
    parameter int PH_W  = 16,
    parameter int LV_W  = 23
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 peak_stb,
    input logic                 valley_stb,
    input logic [CNT_W-1:0]     car_cnt,
    input logic [CNT_W-1:0]     car_per,
    input logic [PH_W-1:0]      theta,
    input logic [PH_W-1:0]      phase_inc,
    input logic [2:0][LV_W-1:0] lvl_q
);

    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(peak_stb && valley_stb)); // R2

    AST_PEAK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        peak_stb |=> !peak_stb); // R2

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        car_cnt <= car_per); // R1

    AST_VALLEY_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        valley_stb |=> (car_cnt == CNT_W'(1))); // R1

    AST_PER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(valley_stb)) |-> $stable(car_per)); // R1

    AST_THETA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (theta == PH_W'($past(theta) + $past(phase_inc)))); // R3

    AST_REF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(peak_stb || valley_stb)) |-> $stable(lvl_q)); // R7

endmodule

bind spwm3_mod spwm3_check #(
    .CNT_W(CNT_W), .PH_W(PH_W), .LV_W(LV_W)
) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .peak_stb  (peak_stb),
    .valley_stb(valley_stb),
    .car_cnt   (car_cnt),
    .car_per   (car_per),
    .theta     (theta_q),
    .phase_inc (phase_inc),
    .lvl_q     (lvl_q)
);

// File: tb/spwm3_mod_bench.sv
module spwm3_mod_bench;

    localparam longint KH = 6 * 2047 * 256;
    localparam longint KF = 2 * KH;
    localparam real    TWO_PI = 6.283185307179586;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  mod_depth = '0;
    logic [15:0] phase_inc = '0;
    logic [11:0] carrier_period = 12'd20;
    logic        inj_en = 1'b0;
    logic        seq_rev = 1'b0;
    logic [2:0]  pwm_hi, pwm_lo;
    logic        peak_stb, valley_stb;

    always #2.5 clk = ~clk;

    spwm3_mod u_spwm3_mod (
        .clk(clk), .rst_n(rst_n), .mod_depth(mod_depth), .phase_inc(phase_inc),
        .carrier_period(carrier_period), .inj_en(inj_en), .seq_rev(seq_rev),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .peak_stb(peak_stb), .valley_stb(valley_stb)
    );

    int     n_tests = 0;
    int     n_fail  = 0;
    string  scen    = "R11 reset";
    bit     cmp_en  = 1'b0;
    bit     sat_hi_seen = 1'b0;
    bit     sat_lo_seen = 1'b0;
    int     sin_tab [256];

    // behavioural model state: 0 start, 1 falling, 2 rising
    int     m_st = 0, m_cnt = 0, m_per = 2, m_theta = 0;
    longint m_lvl [3] = '{KH, KH, KH};

    task automatic chk(bit ok, string req, longint act, longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, scen, act, expv);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            real x;
            x = 2047.0 * $sin(TWO_PI * (real'(i) + 0.5) / 256.0);
            sin_tab[i] = (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
        end
    end

    function automatic longint level_of(int ph, int m, bit inj);
        int     idx;
        longint v, r;
        idx = (ph >> 8) & 255;
        v = 6 * sin_tab[idx] + (inj ? sin_tab[(3 * idx + 1) % 256] : 0);
        r = longint'(m) * v;
        if (r >= KH)  return KF;
        if (r <= -KH) return 0;
        return r + KH;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_per = 2; m_theta = 0;
            for (int p = 0; p < 3; p++) m_lvl[p] = KH;
        end else begin
            bit pk, vl;
            int pb, pc;
            pk = (m_st == 2) && (m_cnt == m_per);
            vl = (m_st == 1) && (m_cnt == 0);
            if (pk || vl) begin
                pb = (m_theta - 21845) & 65535;
                pc = (m_theta + 21845) & 65535;
                m_lvl[0] = level_of(m_theta, int'(mod_depth), inj_en);
                m_lvl[1] = level_of(seq_rev ? pc : pb, int'(mod_depth), inj_en);
                m_lvl[2] = level_of(seq_rev ? pb : pc, int'(mod_depth), inj_en);
            end
            m_theta = (m_theta + int'(phase_inc)) & 65535;
            case (m_st)
                0: m_st = 1;
                1: if (m_cnt == 0) begin
                       m_per = (carrier_period < 2) ? 2 : int'(carrier_period);
                       m_cnt = 1; m_st = 2;
                   end else m_cnt = m_cnt - 1;
                default: if (m_cnt == m_per) begin
                       m_cnt = m_per - 1; m_st = 1;
                   end else m_cnt = m_cnt + 1;
            endcase
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            bit epk, evl, ehi;
            epk = (m_st == 2) && (m_cnt == m_per);
            evl = (m_st == 1) && (m_cnt == 0);
            chk(peak_stb == epk, "R2 peak", peak_stb, epk);
            chk(valley_stb == evl, "R2 valley", valley_stb, evl);
            for (int p = 0; p < 3; p++) begin
                ehi = (m_lvl[p] == KF) || (m_lvl[p] * m_per > KF * m_cnt);
                chk(pwm_hi[p] == ehi, "R6 leg", pwm_hi[p], ehi);
                if (m_lvl[p] == KF) begin
                    sat_hi_seen = 1'b1;
                    chk(pwm_hi[p] == 1'b1, "R8 high saturation", pwm_hi[p], 1);
                end
                if (m_lvl[p] == 0) begin
                    sat_lo_seen = 1'b1;
                    chk(pwm_hi[p] == 1'b0, "R8 low saturation", pwm_hi[p], 0);
                end
            end
            chk(pwm_lo == ~pwm_hi, "R10 complement", pwm_lo, ~pwm_hi);
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(int expv);
        int c;
        @(negedge clk);
        while (!valley_stb) @(negedge clk);
        @(negedge clk);
        c = 1;
        while (!valley_stb) begin
            @(negedge clk);
            c++;
        end
        chk(c == expv, "R1 valley spacing", c, expv);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        cmp_en = 1'b1;
        run(3);
        chk(pwm_hi == 3'b111, "R11 upper", pwm_hi, 7);
        chk(pwm_lo == 3'b000, "R11 lower", pwm_lo, 0);
        chk(!peak_stb && !valley_stb, "R11 strobes", {peak_stb, valley_stb}, 0);
        rst_n = 1'b1;

        scen = "R3 R4 R5 R6 depth 0.5";
        mod_depth = 10'd128; phase_inc = 16'd200;
        run(4000);
        measure(40);

        scen = "R6 depth 1.0";
        mod_depth = 10'd256;
        run(3000);

        scen = "R6 third harmonic at depth 1.13";
        inj_en = 1'b1; mod_depth = 10'd290;
        run(3000);

        scen = "R9 reversed sequence";
        seq_rev = 1'b1;
        run(3000);

        scen = "R7 inputs changed between strobes";
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            mod_depth = 10'((i * 37) % 400);
            inj_en    = i[0];
            seq_rev   = i[1];
        end

        scen = "R8 overmodulation";
        inj_en = 1'b0; seq_rev = 1'b0; mod_depth = 10'd1023;
        run(4000);

        scen = "R1 period below minimum";
        carrier_period = 12'd1;
        measure(4);
        run(200);

        scen = "R1 long period";
        carrier_period = 12'd100; mod_depth = 10'd200; phase_inc = 16'd20;
        measure(200);
        run(3000);

        chk(sat_hi_seen, "R8 high saturation reached", sat_hi_seen, 1);
        chk(sat_lo_seen, "R8 low saturation reached", sat_lo_seen, 1);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired [%s]", scen);
        summary();
        $finish;
    end

endmodule